// File: doc/BRIEF.md
# Layer Readout Controller with Trigger Pulse-Width Measurement

This block sits at one end of a daisy chain of silicon-strip front-end chips and manages the readout of one detector layer. It passes the chain's combined fast-OR trigger on to the tower through an enable gate. It also counts how many clock cycles each fast-OR pulse stays high and queues those widths. When the tower acknowledges a trigger, the block issues a read command to the chain. It then takes in the serial hit bitmap one strip per valid cycle and turns it into a sparse list of hit strip addresses plus a total hit count.

A finished event is placed in one of two ping-pong event buffers, so one event can be filled while the older one waits for its turn on the output line. Output is token-coordinated. When the token arrives from the previous layer, the oldest stored event is shifted out serially, MSB first. It starts with a header word carrying the hit count and the pulse width, followed by one word per stored address in ascending strip order. The token is then handed to the next layer. If no event is stored when the token arrives, the token is handed on at once.

The capture side is a four-state machine. CAP_IDLE waits for an acknowledge. CAP_REQ drives the read command for one cycle. CAP_SHIFT takes in the bitmap. CAP_DONE commits the buffer and pops the pulse-width queue, then returns to CAP_IDLE. The output side is also a four-state machine. SND_IDLE waits for the token and goes to SND_HDR if an event is stored, or to SND_PASS if none is. SND_HDR shifts the header and goes to SND_ADDR, or to SND_PASS for an event with no stored addresses. SND_ADDR shifts the address words and goes to SND_PASS after the last bit. SND_PASS drives the outgoing token for one cycle and returns to SND_IDLE.

Top module: `layer_readout_ctrl`

## Requirements
- R1: `trig_out_o` equals `fast_or_i` AND `trig_en_i` in the same cycle, with no register delay.
- R2: Each fast-OR pulse that is high for L sampling edges yields a width of min(L, 255), held in an 8-bit field. Widths are queued first-in first-out. Each committed event takes the oldest queued width, or 0 when the queue is empty.
- R3: An acknowledge sampled in CAP_IDLE while `busy_o` is low makes `rd_cmd_o` high for exactly the next cycle. Acknowledges sampled while a capture is in progress cause no read command.
- R4: After the read command, the bitmap bits marked by `fe_valid_i` are taken in order, and the first one belongs to strip 0. A 1 bit marks a hit. Cycles with `fe_valid_i` low are skipped. Stored addresses are in ascending strip order.
- R5: The header hit count is the total number of 1 bits in the bitmap, even when it exceeds MAX_HITS. Only the first MAX_HITS addresses are stored and sent. An event with no hits sends only the header.
- R6: `busy_o` is high exactly when both event buffers hold unsent events. An acknowledge sampled while `busy_o` is high produces no read command.
- R7: Event data leave only after a token pulse on `tok_in_i`, and `ser_en_o` is high for exactly the transmitted bits. Each word is 1+CNT_W+8 bits wide and sent MSB first. The header is {1, hit count (CNT_W bits), width (8 bits)}. Each address word is {0, zero padding, address (ADDR_W bits)}.
- R8: `tok_out_o` pulses for one cycle, in the cycle right after the last data bit.
- R9: A token that arrives when no event is stored gives a `tok_out_o` pulse in the next cycle, with no data bits.
- R10: Events are sent in the order they were captured.
- R11: After reset, `busy_o`, `rd_cmd_o`, `tok_out_o` and `ser_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_or_i | input | 1 | Combined fast-OR trigger from the front-end chain |
| trig_en_i | input | 1 | Enable for the trigger forwarded to the tower |
| trig_out_o | output | 1 | Gated trigger toward the tower |
| trig_ack_i | input | 1 | Trigger acknowledge from the tower |
| busy_o | output | 1 | Both event buffers occupied |
| rd_cmd_o | output | 1 | One-cycle read command to the front-end chain |
| fe_valid_i | input | 1 | Qualifies a bitmap bit on fe_data_i |
| fe_data_i | input | 1 | Serial hit bitmap, strip 0 first |
| tok_in_i | input | 1 | Token pulse from the previous layer |
| tok_out_o | output | 1 | Token pulse to the next layer |
| ser_en_o | output | 1 | Marks valid bits on ser_o |
| ser_o | output | 1 | Serial event data, MSB first |

## Verification
The bench builds the block with 40 strips and room for 8 stored addresses per event, keeping the 8-bit width field and a 4-entry width queue. This makes 6-bit addresses and counts and 15-bit words. With these values, a whole bitmap shifts in a few dozen cycles, and an event with 10 hits reaches the truncation limit. A 300-cycle fast-OR pulse drives the width counter past its saturation point. Filling both buffers before any token arrives exercises the busy hold-off and the oldest-first send order.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_REQ,
        CAP_SHIFT,
        CAP_DONE
    } cap_state_t;

    typedef enum logic [1:0] {
        SND_IDLE,
        SND_HDR,
        SND_ADDR,
        SND_PASS
    } snd_state_t;

endpackage

// File: rtl/lrc_tot.sv
// Pulse-width counter for the fast-OR and a small FIFO of measured widths.
module lrc_tot #(
    parameter int TOT_W = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_or_i,
    input  logic             pop_i,
    output logic [TOT_W-1:0] tot_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam logic [TOT_W-1:0] TOT_MAX = '1;

    logic              fo_q;
    logic [TOT_W-1:0]  run_q;
    logic [TOT_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [FILL_W-1:0] fill_q;
    logic              push;
    logic              pop;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // A pulse ends when the sampled level falls; its width is queued then.
    assign push = fo_q && !fast_or_i && (fill_q != FILL_W'(DEPTH));
    assign pop  = pop_i && (fill_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fo_q     <= 1'b0;
            run_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            fo_q <= fast_or_i;
            if (fast_or_i) begin
                if (!fo_q) begin
                    run_q <= TOT_W'(1);
                end else if (run_q != TOT_MAX) begin
                    run_q <= run_q + 1'b1;
                end
            end
            if (push) begin
                wr_ptr_q <= next_ptr(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= next_ptr(rd_ptr_q);
            end
            if (push && !pop) begin
                fill_q <= fill_q + 1'b1;
            end else if (pop && !push) begin
                fill_q <= fill_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr_q] <= run_q;
        end
    end

    assign tot_o = (fill_q == '0) ? '0 : mem[rd_ptr_q];

endmodule

// File: rtl/lrc_evbuf.sv
// Two ping-pong event banks: address list, hit count, width and occupancy.
module lrc_evbuf #(
    parameter int ADDR_W    = 11,
    parameter int CNT_W     = 11,
    parameter int TOT_W     = 8,
    parameter int MAX_HITS  = 64,
    parameter int HIT_IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 wr_bank_i,
    input  logic [HIT_IDX_W-1:0] wr_idx_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic                 commit_i,
    input  logic [CNT_W-1:0]     commit_cnt_i,
    input  logic [TOT_W-1:0]     commit_tot_i,
    input  logic                 release_i,
    input  logic                 rd_bank_i,
    input  logic [HIT_IDX_W-1:0] rd_idx_i,
    output logic [ADDR_W-1:0]    rd_addr_o,
    output logic [CNT_W-1:0]     rd_cnt_o,
    output logic [TOT_W-1:0]     rd_tot_o,
    output logic [1:0]           full_o
);
    logic [ADDR_W-1:0] bank_addr [2];
    logic [CNT_W-1:0]  bank_cnt  [2];
    logic [TOT_W-1:0]  bank_tot  [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [ADDR_W-1:0] mem [MAX_HITS];
        logic [CNT_W-1:0]  cnt_q;
        logic [TOT_W-1:0]  tot_q;
        logic              full_q;
        logic              sel_wr;
        logic              sel_rd;

        assign sel_wr = (wr_bank_i == 1'(b));
        assign sel_rd = (rd_bank_i == 1'(b));

        always_ff @(posedge clk) begin
            if (wr_en_i && sel_wr) begin
                mem[wr_idx_i] <= wr_addr_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                tot_q  <= '0;
                full_q <= 1'b0;
            end else if (commit_i && sel_wr) begin
                cnt_q  <= commit_cnt_i;
                tot_q  <= commit_tot_i;
                full_q <= 1'b1;
            end else if (release_i && sel_rd) begin
                full_q <= 1'b0;
            end
        end

        assign bank_addr[b] = mem[rd_idx_i];
        assign bank_cnt[b]  = cnt_q;
        assign bank_tot[b]  = tot_q;
        assign full_o[b]    = full_q;
    end

    assign rd_addr_o = bank_addr[rd_bank_i];
    assign rd_cnt_o  = bank_cnt[rd_bank_i];
    assign rd_tot_o  = bank_tot[rd_bank_i];

endmodule

// File: rtl/lrc_capture.sv
// Read command issue and bitmap-to-address-list conversion.
module lrc_capture
    import lrc_pkg::*;
#(
    parameter int NSTRIP    = 1600,
    parameter int MAX_HITS  = 64,
    parameter int ADDR_W    = 11,
    parameter int CNT_W     = 11,
    parameter int HIT_IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_ack_i,
    input  logic                 busy_i,
    input  logic                 fe_valid_i,
    input  logic                 fe_data_i,
    output logic                 rd_cmd_o,
    output logic                 bank_o,
    output logic                 wr_en_o,
    output logic [HIT_IDX_W-1:0] wr_idx_o,
    output logic [ADDR_W-1:0]    wr_addr_o,
    output logic                 commit_o,
    output logic [CNT_W-1:0]     commit_cnt_o
);
    cap_state_t        state_q;
    cap_state_t        state_d;
    logic [ADDR_W-1:0] strip_q;
    logic [CNT_W-1:0]  hits_q;
    logic              bank_q;
    logic              last_strip;
    logic              room;

    assign last_strip = (strip_q == ADDR_W'(NSTRIP - 1));
    assign room       = (hits_q < CNT_W'(MAX_HITS));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:  if (trig_ack_i && !busy_i) state_d = CAP_REQ;
            CAP_REQ:   state_d = CAP_SHIFT;
            CAP_SHIFT: if (fe_valid_i && last_strip) state_d = CAP_DONE;
            CAP_DONE:  state_d = CAP_IDLE;
            default:   state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            strip_q <= '0;
            hits_q  <= '0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                CAP_REQ: begin
                    strip_q <= '0;
                    hits_q  <= '0;
                end
                CAP_SHIFT: begin
                    if (fe_valid_i) begin
                        strip_q <= strip_q + 1'b1;
                        if (fe_data_i) begin
                            hits_q <= hits_q + 1'b1;
                        end
                    end
                end
                CAP_DONE: bank_q <= ~bank_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_cmd_o     = (state_q == CAP_REQ);
        wr_en_o      = (state_q == CAP_SHIFT) && fe_valid_i && fe_data_i && room;
        wr_idx_o     = hits_q[HIT_IDX_W-1:0];
        wr_addr_o    = strip_q;
        commit_o     = (state_q == CAP_DONE);
        commit_cnt_o = hits_q;
        bank_o       = bank_q;
    end

endmodule

// File: rtl/lrc_sender.sv
// Token-coordinated serial transmitter of stored events.
module lrc_sender
    import lrc_pkg::*;
#(
    parameter int WORD_W    = 20,
    parameter int ADDR_W    = 11,
    parameter int CNT_W     = 11,
    parameter int TOT_W     = 8,
    parameter int MAX_HITS  = 64,
    parameter int HIT_IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tok_in_i,
    input  logic [1:0]           full_i,
    input  logic [CNT_W-1:0]     rd_cnt_i,
    input  logic [TOT_W-1:0]     rd_tot_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic                 rd_bank_o,
    output logic [HIT_IDX_W-1:0] rd_idx_o,
    output logic                 release_o,
    output logic                 tok_out_o,
    output logic                 ser_en_o,
    output logic                 ser_o
);
    localparam int BIT_W   = $clog2(WORD_W);
    localparam int NSEND_W = $clog2(MAX_HITS + 1);

    snd_state_t           state_q;
    snd_state_t           state_d;
    logic                 bank_q;
    logic [BIT_W-1:0]     bit_q;
    logic [HIT_IDX_W-1:0] word_q;
    logic [NSEND_W-1:0]   nword_q;
    logic [NSEND_W-1:0]   nword_in;
    logic                 last_bit;
    logic                 last_word;
    logic                 ready;
    logic [WORD_W-1:0]    cur_word;

    assign ready     = full_i[bank_q];
    assign last_bit  = (bit_q == '0);
    assign last_word = ((NSEND_W'(word_q) + 1'b1) == nword_q);
    assign nword_in  = (rd_cnt_i > CNT_W'(MAX_HITS)) ? NSEND_W'(MAX_HITS)
                                                     : NSEND_W'(rd_cnt_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SND_IDLE: if (tok_in_i) state_d = ready ? SND_HDR : SND_PASS;
            SND_HDR:  if (last_bit) state_d = (nword_q == '0) ? SND_PASS : SND_ADDR;
            SND_ADDR: if (last_bit && last_word) state_d = SND_PASS;
            SND_PASS: state_d = SND_IDLE;
            default:  state_d = SND_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SND_IDLE;
            bank_q  <= 1'b0;
            bit_q   <= '0;
            word_q  <= '0;
            nword_q <= '0;
        end else begin
            state_q <= state_d;
            if (release_o) begin
                bank_q <= ~bank_q;
            end
            unique case (state_q)
                SND_IDLE: begin
                    bit_q   <= BIT_W'(WORD_W - 1);
                    word_q  <= '0;
                    nword_q <= nword_in;
                end
                SND_HDR, SND_ADDR: begin
                    if (last_bit) begin
                        bit_q <= BIT_W'(WORD_W - 1);
                        if (state_q == SND_ADDR) begin
                            word_q <= word_q + 1'b1;
                        end
                    end else begin
                        bit_q <= bit_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cur_word  = (state_q == SND_HDR) ? {1'b1, rd_cnt_i, rd_tot_i}
                                         : WORD_W'(rd_addr_i);
        ser_en_o  = (state_q == SND_HDR) || (state_q == SND_ADDR);
        ser_o     = ser_en_o && cur_word[bit_q];
        tok_out_o = (state_q == SND_PASS);
        release_o = last_bit && (((state_q == SND_HDR) && (nword_q == '0)) ||
                                 ((state_q == SND_ADDR) && last_word));
        rd_bank_o = bank_q;
        rd_idx_o  = word_q;
    end

endmodule

// File: rtl/layer_readout_ctrl.sv
// Layer readout controller: trigger gate, pulse width, sparse capture, token output.
module layer_readout_ctrl #(
    parameter int NSTRIP    = 1600,
    parameter int MAX_HITS  = 64,
    parameter int TOT_W     = 8,
    parameter int TOT_DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_or_i,
    input  logic trig_en_i,
    output logic trig_out_o,
    input  logic trig_ack_i,
    output logic busy_o,
    output logic rd_cmd_o,
    input  logic fe_valid_i,
    input  logic fe_data_i,
    input  logic tok_in_i,
    output logic tok_out_o,
    output logic ser_en_o,
    output logic ser_o
);
    localparam int ADDR_W    = $clog2(NSTRIP);
    localparam int CNT_W     = $clog2(NSTRIP + 1);
    localparam int WORD_W    = 1 + CNT_W + TOT_W;
    localparam int HIT_IDX_W = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1;

    logic                 wr_en;
    logic                 wr_bank;
    logic [HIT_IDX_W-1:0] wr_idx;
    logic [ADDR_W-1:0]    wr_addr;
    logic                 commit;
    logic [CNT_W-1:0]     commit_cnt;
    logic [TOT_W-1:0]     tot_head;
    logic                 rel;
    logic                 rd_bank;
    logic [HIT_IDX_W-1:0] rd_idx;
    logic [ADDR_W-1:0]    rd_addr;
    logic [CNT_W-1:0]     rd_cnt;
    logic [TOT_W-1:0]     rd_tot;
    logic [1:0]           full;

    assign trig_out_o = fast_or_i && trig_en_i;
    assign busy_o     = &full;

    lrc_tot #(
        .TOT_W (TOT_W),
        .DEPTH (TOT_DEPTH)
    ) i_tot (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_or_i (fast_or_i),
        .pop_i     (commit),
        .tot_o     (tot_head)
    );

    lrc_capture #(
        .NSTRIP    (NSTRIP),
        .MAX_HITS  (MAX_HITS),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .HIT_IDX_W (HIT_IDX_W)
    ) i_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_ack_i   (trig_ack_i),
        .busy_i       (busy_o),
        .fe_valid_i   (fe_valid_i),
        .fe_data_i    (fe_data_i),
        .rd_cmd_o     (rd_cmd_o),
        .bank_o       (wr_bank),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .wr_addr_o    (wr_addr),
        .commit_o     (commit),
        .commit_cnt_o (commit_cnt)
    );

    lrc_evbuf #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .TOT_W     (TOT_W),
        .MAX_HITS  (MAX_HITS),
        .HIT_IDX_W (HIT_IDX_W)
    ) i_evbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_bank_i    (wr_bank),
        .wr_idx_i     (wr_idx),
        .wr_addr_i    (wr_addr),
        .commit_i     (commit),
        .commit_cnt_i (commit_cnt),
        .commit_tot_i (tot_head),
        .release_i    (rel),
        .rd_bank_i    (rd_bank),
        .rd_idx_i     (rd_idx),
        .rd_addr_o    (rd_addr),
        .rd_cnt_o     (rd_cnt),
        .rd_tot_o     (rd_tot),
        .full_o       (full)
    );

    lrc_sender #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .TOT_W     (TOT_W),
        .MAX_HITS  (MAX_HITS),
        .HIT_IDX_W (HIT_IDX_W)
    ) i_sender (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_in_i  (tok_in_i),
        .full_i    (full),
        .rd_cnt_i  (rd_cnt),
        .rd_tot_i  (rd_tot),
        .rd_addr_i (rd_addr),
        .rd_bank_o (rd_bank),
        .rd_idx_o  (rd_idx),
        .release_o (rel),
        .tok_out_o (tok_out_o),
        .ser_en_o  (ser_en_o),
        .ser_o     (ser_o)
    );

endmodule

// File: rtl/lrc_checker.sv
module lrc_checker (
    input logic clk,
    input logic rst_n,
    input logic trig_ack_i,
    input logic busy_o,
    input logic rd_cmd_o,
    input logic tok_in_i,
    input logic tok_out_o,
    input logic ser_en_o
);
    AST_CMD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_o |-> $past(trig_ack_i)); // R3
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_o |=> !rd_cmd_o); // R3
    AST_NO_CMD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_o |-> !$past(busy_o)); // R6
    AST_SER_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_en_o) |-> $past(tok_in_i)); // R7
    AST_TOK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out_o |=> !tok_out_o); // R8
    AST_TOK_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out_o |-> !ser_en_o); // R8
endmodule

bind layer_readout_ctrl lrc_checker i_lrc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_ack_i (trig_ack_i),
    .busy_o     (busy_o),
    .rd_cmd_o   (rd_cmd_o),
    .tok_in_i   (tok_in_i),
    .tok_out_o  (tok_out_o),
    .ser_en_o   (ser_en_o)
);

// File: tb/test_layer_readout_ctrl.sv
module test_layer_readout_ctrl;
    localparam int NS   = 40;
    localparam int MH   = 8;
    localparam int TOTW = 8;
    localparam int CW   = $clog2(NS + 1);
    localparam int WW   = 1 + CW + TOTW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fast_or = 1'b0, trig_en = 1'b0, trig_ack = 1'b0;
    logic fe_valid = 1'b0, fe_data = 1'b0, tok_in = 1'b0;
    logic trig_out_o, busy_o, rd_cmd_o, tok_out_o, ser_en_o, ser_o;
    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    layer_readout_ctrl #(.NSTRIP(NS), .MAX_HITS(MH), .TOT_W(TOTW), .TOT_DEPTH(4)) i_layer_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .fast_or_i(fast_or), .trig_en_i(trig_en),
        .trig_out_o(trig_out_o), .trig_ack_i(trig_ack), .busy_o(busy_o),
        .rd_cmd_o(rd_cmd_o), .fe_valid_i(fe_valid), .fe_data_i(fe_data),
        .tok_in_i(tok_in), .tok_out_o(tok_out_o), .ser_en_o(ser_en_o), .ser_o(ser_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tot_pulse(input int len);
        @(negedge clk) fast_or = 1'b1;
        repeat (len) @(posedge clk);
        @(negedge clk) fast_or = 1'b0;
        @(negedge clk);
    endtask

    task automatic capture(input logic [NS-1:0] bm, input bit ack_mid, input string tag);
        int extra = 0;
        @(negedge clk) trig_ack = 1'b1;
        @(negedge clk) trig_ack = 1'b0;
        chk(rd_cmd_o == 1'b1, {"R3 read command after ack ", tag}, rd_cmd_o, 1);
        @(negedge clk);
        chk(rd_cmd_o == 1'b0, {"R3 read command one cycle ", tag}, rd_cmd_o, 0);
        for (int i = 0; i < NS; i++) begin
            if (i % 7 == 3) begin
                fe_valid = 1'b0;
                fe_data  = 1'b1;
                @(negedge clk);
                extra += int'(rd_cmd_o);
            end
            fe_valid = 1'b1;
            fe_data  = bm[i];
            trig_ack = ack_mid && (i == NS / 2);
            @(negedge clk);
            extra += int'(rd_cmd_o);
        end
        fe_valid = 1'b0;
        fe_data  = 1'b0;
        trig_ack = 1'b0;
        @(negedge clk);
        extra += int'(rd_cmd_o);
        chk(extra == 0, {"R3 no command during capture ", tag}, extra, 0);
    endtask

    task automatic send_check(input logic [NS-1:0] bm, input int tot, input string tag);
        logic [WW-1:0] expw [MH + 1];
        logic [WW-1:0] got [MH + 1];
        logic [WW-1:0] sh = '0;
        int h = 0, nexp, nb = 0, nw = 0, guard = 0;
        bit seen = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (bm[i]) begin
                if (h < MH) expw[1 + h] = WW'(i);
                h++;
            end
        end
        expw[0] = {1'b1, CW'(h), TOTW'((tot > 255) ? 255 : tot)};
        nexp = 1 + ((h > MH) ? MH : h);
        for (int k = 0; k <= MH; k++) got[k] = '0;
        @(negedge clk) tok_in = 1'b1;
        @(negedge clk) tok_in = 1'b0;
        while (!seen && guard < 2000) begin
            if (ser_en_o) begin
                sh = {sh[WW-2:0], ser_o};
                nb++;
                if (nb == WW) begin
                    if (nw <= MH) got[nw] = sh;
                    nw++;
                    nb = 0;
                end
            end
            if (tok_out_o) seen = 1'b1;
            else @(negedge clk);
            guard++;
        end
        chk(seen, {"R8 token passed ", tag}, seen, 1);
        chk(nw == nexp && nb == 0, {"R7 word count ", tag}, nw, nexp);
        for (int k = 0; k < nexp; k++)
            chk(got[k] == expw[k], {"R7 word content ", tag}, got[k], expw[k]);
        @(negedge clk);
        chk(tok_out_o == 1'b0, {"R8 token one cycle ", tag}, tok_out_o, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy_o == 0 && rd_cmd_o == 0, "R11 reset busy/cmd", {busy_o, rd_cmd_o}, 0);
        chk(tok_out_o == 0 && ser_en_o == 0, "R11 reset token/serial", {tok_out_o, ser_en_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_single();
        logic [NS-1:0] bm = '0;
        bm[0] = 1'b1; bm[3] = 1'b1; bm[39] = 1'b1;
        tot_pulse(5);
        capture(bm, 1'b0, "single");
        chk(busy_o == 0, "R6 one buffer not busy", busy_o, 0);
        send_check(bm, 5, "R4 R2 single");
    endtask

    task automatic t_empty();
        capture('0, 1'b0, "empty");
        send_check('0, 0, "R5 R2 empty event");
    endtask

    task automatic t_trunc();
        logic [NS-1:0] bm = '0;
        bm[1] = 1; bm[2] = 1; bm[5] = 1; bm[8] = 1; bm[13] = 1;
        bm[20] = 1; bm[21] = 1; bm[30] = 1; bm[35] = 1; bm[38] = 1;
        tot_pulse(300);
        capture(bm, 1'b1, "trunc");
        send_check(bm, 300, "R5 R2 truncation saturation");
    endtask

    task automatic t_busy_order();
        logic [NS-1:0] a = '0;
        logic [NS-1:0] b = '0;
        int cmds = 0;
        a[7] = 1; a[11] = 1;
        b[0] = 1; b[22] = 1; b[23] = 1; b[24] = 1;
        tot_pulse(7);
        tot_pulse(9);
        capture(a, 1'b0, "A");
        capture(b, 1'b0, "B");
        chk(busy_o == 1, "R6 both buffers busy", busy_o, 1);
        @(negedge clk) trig_ack = 1'b1;
        @(negedge clk) trig_ack = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cmds += int'(rd_cmd_o);
            @(negedge clk);
        end
        chk(cmds == 0, "R6 ack while busy ignored", cmds, 0);
        send_check(a, 7, "R10 first event");
        chk(busy_o == 0, "R6 busy clears after send", busy_o, 0);
        send_check(b, 9, "R10 second event");
    endtask

    task automatic t_pass();
        @(negedge clk) tok_in = 1'b1;
        @(negedge clk) tok_in = 1'b0;
        chk(tok_out_o == 1 && ser_en_o == 0, "R9 empty token pass", {tok_out_o, ser_en_o}, 2);
        @(negedge clk);
        chk(tok_out_o == 0 && ser_en_o == 0, "R9 no data after pass", {tok_out_o, ser_en_o}, 0);
    endtask

    task automatic t_gate();
        @(negedge clk) begin trig_en = 1'b0; fast_or = 1'b1; end
        #1 chk(trig_out_o == 0, "R1 gate closed", trig_out_o, 0);
        trig_en = 1'b1;
        #1 chk(trig_out_o == 1, "R1 gate open", trig_out_o, 1);
        fast_or = 1'b0;
        #1 chk(trig_out_o == 0, "R1 fast-OR low", trig_out_o, 0);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_single();
        t_empty();
        t_trunc();
        t_busy_order();
        t_gate();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule